// File: doc/BRIEF.md
# Port-to-System Address Translator

This block turns a 40-bit memory-channel port address back into the system real address that the channel interleave produced. It takes the port address together with three pieces of configuration: the 3-bit group identifier, the 11-bit group-size field, and the number of channels that share the group.

With power-of-two interleave (1, 2, 4 or 8 channels), the low group-identifier bits that picked the channel were dropped from the port address. The block puts them back just above the 7-bit line offset and moves the upper address field up to make room. With 3 or 6 channel interleave, the channel was picked by a modulo-3 hash over several address bit pairs. The two most significant port-address bits were consumed by that hash. The block recovers them by inverting the hash: it finds how many single-step rotations carry the group's target code onto the code computed from the address, then ORs that count in at a bit position set by the group size.

The translator has one register stage. A request presented with `in_valid` high produces its result one clock later, with `out_valid` high.

Top module: `pa2ra_xlate`

## Requirements
- R1: With 1 channel per group, the output address equals the port address zero-extended to 43 bits.
- R2: With 2, 4 or 8 channels, the low 1, 2 or 3 group-ID bits respectively are placed at output bits starting at bit 7. Output bits [6:0] equal port bits [6:0]. Port bits [39:7] appear shifted up by the number of inserted bits.
- R3: With 3 channels, no bits are inserted. The output is the port address ORed with the recovered MSB value.
- R4: With 6 channels, group-ID bit 0 is inserted at bit 7 as in the 2-channel case. The hash solve uses the group ID with bit 0 cleared and the selector pair with bit 7 taken as zero.
- R5: The recovered MSB value is k in 0..2, where k = (g - s - h) mod 3. Here g is the group ID used, s is the 2-bit value of address bits [8:7] used, and h = (A + B + C) mod 3, with A, B and C the 2-bit values at address bits [16:15], [18:17] and [20:19] after insertion.
- R6: The MSB value is shifted left by 30 plus the number of set bits in the 11-bit group-size field before it is ORed in.
- R7: A channel count other than 1, 2, 3, 4, 6 or 8 sets `out_cfg_bad` and passes the port address through unchanged. Valid counts clear `out_cfg_bad`.
- R8: A result appears exactly one cycle after its request, with `out_valid` high. Reset clears `out_valid` and the output address.
- R9: `out_hash_err` stays low for every valid request, since some rotation count in 0..2 always matches.
- R10: While `in_valid` is low, the output address and flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_port_addr | input | 40 | Channel port address |
| in_grp_id | input | 3 | Group identifier |
| in_grp_size | input | 11 | Group-size field; its population count sets the MSB position |
| in_chnls | input | 4 | Channels per group, as a plain count |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_sys_addr | output | 43 | Rebuilt system real address |
| out_cfg_bad | output | 1 | Unsupported channel count seen |
| out_hash_err | output | 1 | No rotation count matched in the hash solve |

## Verification
The hardest case to reach is 6-channel mode, where several things happen at once. The inserted group bit shifts the hash fields, and bit 7 plus the group-ID LSB must be kept out of the solve. Together these give recovered MSB values that differ from the 3-channel answer for the same inputs. The stimulus reaches this case by pairing odd and even group IDs with port addresses whose bit pairs sum to each residue. All three rotation counts are driven in both hash modes. The group size is swept from zero set bits to all eleven, which puts the recovered bits at the top of the 43-bit output.

// File: rtl/pa2ra_pkg.sv
package pa2ra_pkg;

  typedef enum logic [2:0] {
    CM_PASS = 3'd0,
    CM_INS  = 3'd1,
    CM_M3   = 3'd2,
    CM_M6   = 3'd3,
    CM_BAD  = 3'd4
  } chan_mode_e;

  // one-hot residue code: residue 0 -> 100, 1 -> 010, 2 -> 001
  function automatic logic [2:0] res_code(input logic [2:0] v);
    case (v)
      3'd0, 3'd3, 3'd6: res_code = 3'b100;
      3'd1, 3'd4, 3'd7: res_code = 3'b010;
      default:          res_code = 3'b001;
    endcase
  endfunction

  function automatic logic [2:0] rot_r(input logic [2:0] c, input logic [1:0] n);
    logic [2:0] t;
    t = c;
    for (int i = 0; i < 3; i++)
      if (i < int'(n)) t = {t[0], t[2:1]};
    rot_r = t;
  endfunction

  function automatic logic [2:0] rot_l(input logic [2:0] c, input logic [1:0] n);
    logic [2:0] t;
    t = c;
    for (int i = 0; i < 3; i++)
      if (i < int'(n)) t = {t[1:0], t[2]};
    rot_l = t;
  endfunction

endpackage

// File: rtl/pa2ra_insert.sv
module pa2ra_insert
  import pa2ra_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int OFF_W = 7,
  parameter int GID_W = 3,
  parameter int RA_W  = 43
) (
  input  logic [PA_W-1:0]  pa,
  input  logic [GID_W-1:0] gid,
  input  logic [3:0]       chnls,
  output logic [RA_W-1:0]  ins_addr,
  output chan_mode_e       mode
);
  localparam int NCAND = GID_W + 1;

  logic [RA_W-1:0] cand [NCAND];
  logic [1:0]      n_ins;

  genvar n;
  generate
    for (n = 0; n < NCAND; n++) begin : g_cand
      localparam logic [GID_W-1:0] GMASK = GID_W'((1 << n) - 1);
      assign cand[n] = (RA_W'(pa[PA_W-1:OFF_W]) << (OFF_W + n))
                     | (RA_W'(gid & GMASK) << OFF_W)
                     | RA_W'(pa[OFF_W-1:0]);
    end
  endgenerate

  always_comb begin
    n_ins = 2'd0;
    mode  = CM_PASS;
    case (chnls)
      4'd1:    begin n_ins = 2'd0; mode = CM_PASS; end
      4'd2:    begin n_ins = 2'd1; mode = CM_INS;  end
      4'd4:    begin n_ins = 2'd2; mode = CM_INS;  end
      4'd8:    begin n_ins = 2'd3; mode = CM_INS;  end
      4'd3:    begin n_ins = 2'd0; mode = CM_M3;   end
      4'd6:    begin n_ins = 2'd1; mode = CM_M6;   end
      default: begin n_ins = 2'd0; mode = CM_BAD;  end
    endcase
    ins_addr = cand[n_ins];
  end

endmodule

// File: rtl/pa2ra_m3solve.sv
module pa2ra_m3solve
  import pa2ra_pkg::*;
#(
  parameter int RA_W    = 43,
  parameter int GID_W   = 3,
  parameter int SEL_LO  = 7,
  parameter int HASH_LO = 15
) (
  input  logic [RA_W-1:0]  ra,
  input  logic [GID_W-1:0] gid,
  input  logic             six_ch,
  output logic [1:0]       msb_val,
  output logic [2:0]       match,
  output logic             no_match
);
  logic [2:0]       h0, h1, h2, tgt;
  logic [GID_W-1:0] g_use;
  logic [1:0]       s_use;
  logic [2:0]       step [3];

  always_comb begin
    h0    = res_code({1'b0, ra[HASH_LO+1:HASH_LO]});
    h1    = rot_r(h0, ra[HASH_LO+3:HASH_LO+2]);
    h2    = rot_r(h1, ra[HASH_LO+5:HASH_LO+4]);
    g_use = six_ch ? (gid & ~GID_W'(1)) : gid;
    s_use = six_ch ? {ra[SEL_LO+1], 1'b0} : ra[SEL_LO+1:SEL_LO];
    tgt   = rot_l(res_code(g_use), s_use);
  end

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_step
      assign step[k]  = rot_l(tgt, 2'(k));
      assign match[k] = (step[k] == h2);
    end
  endgenerate

  always_comb begin
    no_match = ~|match;
    if (match[0])      msb_val = 2'd0;
    else if (match[1]) msb_val = 2'd1;
    else if (match[2]) msb_val = 2'd2;
    else               msb_val = 2'd0;
  end

  always_comb begin
    AST_ONE_ROTATION: assert ($countones(match) == 1); // R5
  end

endmodule

// File: rtl/pa2ra_msbplace.sv
module pa2ra_msbplace #(
  parameter int RA_W     = 43,
  parameter int GSZ_W    = 11,
  parameter int MSB_BASE = 30
) (
  input  logic [GSZ_W-1:0] gsize,
  input  logic [1:0]       msb_val,
  output logic [RA_W-1:0]  msb_field
);
  localparam int PC_W = $clog2(GSZ_W + 1);

  logic [PC_W-1:0] pc;
  int              sh;

  always_comb begin
    pc = '0;
    for (int i = 0; i < GSZ_W; i++) pc = pc + PC_W'(gsize[i]);
    sh        = MSB_BASE + int'(pc);
    msb_field = RA_W'(msb_val) << sh;
  end

  always_comb begin
    AST_MSB_WIDTH: assert ($countones(msb_field) <= 2); // R6
  end

endmodule

// File: rtl/pa2ra_xlate.sv
module pa2ra_xlate
  import pa2ra_pkg::*;
#(
  parameter int PA_W     = 40,
  parameter int OFF_W    = 7,
  parameter int GID_W    = 3,
  parameter int GSZ_W    = 11,
  parameter int MSB_BASE = 30,
  parameter int HASH_LO  = 15,
  parameter int RA_W     = PA_W + GID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PA_W-1:0]  in_port_addr,
  input  logic [GID_W-1:0] in_grp_id,
  input  logic [GSZ_W-1:0] in_grp_size,
  input  logic [3:0]       in_chnls,
  output logic             out_valid,
  output logic [RA_W-1:0]  out_sys_addr,
  output logic             out_cfg_bad,
  output logic             out_hash_err
);
  chan_mode_e      mode;
  logic [RA_W-1:0] ins_addr, msb_field, nxt_addr;
  logic [1:0]      msb_val;
  logic [2:0]      match;
  logic            no_match, hash_mode, nxt_err;

  pa2ra_insert #(.PA_W(PA_W), .OFF_W(OFF_W), .GID_W(GID_W), .RA_W(RA_W)) u_ins (
    .pa(in_port_addr), .gid(in_grp_id), .chnls(in_chnls),
    .ins_addr(ins_addr), .mode(mode)
  );

  pa2ra_m3solve #(.RA_W(RA_W), .GID_W(GID_W), .SEL_LO(OFF_W), .HASH_LO(HASH_LO)) u_solve (
    .ra(ins_addr), .gid(in_grp_id), .six_ch(mode == CM_M6),
    .msb_val(msb_val), .match(match), .no_match(no_match)
  );

  pa2ra_msbplace #(.RA_W(RA_W), .GSZ_W(GSZ_W), .MSB_BASE(MSB_BASE)) u_place (
    .gsize(in_grp_size), .msb_val(msb_val), .msb_field(msb_field)
  );

  always_comb begin
    hash_mode = (mode == CM_M3) || (mode == CM_M6);
    nxt_addr  = hash_mode ? (ins_addr | msb_field) : ins_addr;
    nxt_err   = hash_mode && no_match;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sys_addr <= '0;
      out_cfg_bad  <= 1'b0;
      out_hash_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sys_addr <= nxt_addr;
        out_cfg_bad  <= (mode == CM_BAD);
        out_hash_err <= nxt_err;
      end
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_ONE_CH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chnls == 4'd1) |=> out_sys_addr == RA_W'($past(in_port_addr))); // R1
  AST_LINE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_sys_addr[OFF_W-1:0] == $past(in_port_addr[OFF_W-1:0])); // R2
  AST_FOUR_CH_GID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chnls == 4'd4) |=> out_sys_addr[OFF_W+1:OFF_W] == $past(in_grp_id[1:0])); // R2
  AST_BAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cfg_bad) |-> out_sys_addr == RA_W'($past(in_port_addr))); // R7
  AST_NO_HASH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_hash_err); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sys_addr) && $stable(out_cfg_bad)); // R10

endmodule

// File: tb/pa2ra_xlate_tb.sv
module pa2ra_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [39:0] in_port_addr;
  logic [2:0]  in_grp_id;
  logic [10:0] in_grp_size;
  logic [3:0]  in_chnls;
  logic        out_valid;
  logic [42:0] out_sys_addr;
  logic        out_cfg_bad;
  logic        out_hash_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pa2ra_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_port_addr(in_port_addr), .in_grp_id(in_grp_id),
    .in_grp_size(in_grp_size), .in_chnls(in_chnls),
    .out_valid(out_valid), .out_sys_addr(out_sys_addr),
    .out_cfg_bad(out_cfg_bad), .out_hash_err(out_hash_err)
  );

  // reference: arithmetic restatement of the requirements
  function automatic logic [63:0] ref_addr(input logic [39:0] pa, input int gid,
                                           input int gsz, input int ch);
    logic [63:0] up, lo, ra;
    int nins, g, s, h, a, b, c, k, pc;
    up = 64'(pa) >> 7;
    lo = 64'(pa) & 64'h7f;
    case (ch)
      2: nins = 1; 4: nins = 2; 8: nins = 3; 6: nins = 1;
      default: nins = 0;
    endcase
    ra = (up * (64'd1 << (7 + nins))) + (64'(gid % (1 << nins)) * 128) + lo;
    if (ch == 3 || ch == 6) begin
      a = int'(ra[16:15]); b = int'(ra[18:17]); c = int'(ra[20:19]);
      h = (a + b + c) % 3;
      g = (ch == 6) ? (gid / 2) * 2 : gid;
      s = (ch == 6) ? int'(ra[8]) * 2 : int'(ra[8:7]);
      k = ((g - s - h) % 3 + 6) % 3;
      pc = 0;
      for (int i = 0; i < 11; i++) pc += (gsz >> i) & 1;
      ra = ra | (64'(k) << (30 + pc));
    end
    ref_addr = ra;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic issue(input logic [39:0] pa, input int gid, input int gsz, input int ch);
    in_valid     = 1'b1;
    in_port_addr = pa;
    in_grp_id    = 3'(gid);
    in_grp_size  = 11'(gsz);
    in_chnls     = 4'(ch);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [39:0] pa, input int gid,
                         input int gsz, input int ch);
    logic bad;
    issue(pa, gid, gsz, ch);
    bad = !(ch == 1 || ch == 2 || ch == 3 || ch == 4 || ch == 6 || ch == 8);
    check(req, 64'(out_sys_addr), bad ? 64'(pa) : ref_addr(pa, gid, gsz, ch));
    check({req, " R8 valid"}, 64'(out_valid), 64'd1);
    check({req, " R7 flag"}, 64'(out_cfg_bad), 64'(bad));
    check({req, " R9 err"}, 64'(out_hash_err), 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_port_addr = '0; in_grp_id = '0;
    in_grp_size = '0; in_chnls = 4'd1;
    repeat (3) @(negedge clk);
    check("R8 reset valid", 64'(out_valid), 64'd0);
    check("R8 reset addr", 64'(out_sys_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_pass;
    run_one("R1 one-ch", 40'hAB_CDEF_1234, 5, 3, 1);
    run_one("R1 one-ch max", 40'hFF_FFFF_FFFF, 7, 2047, 1);
  endtask

  task automatic t_insert;
    run_one("R2 two-ch", 40'h12_3456_789A, 3, 0, 2);
    run_one("R2 four-ch", 40'h80_0000_00FF, 6, 0, 4);
    run_one("R2 eight-ch", 40'hFF_FFFF_FF80, 5, 0, 8);
    run_one("R2 eight-ch low", 40'h00_0000_007F, 7, 0, 8);
  endtask

  task automatic t_mod3;
    // cover every rotation count in 3-channel mode
    for (int gid = 0; gid < 8; gid++)
      for (int v = 0; v < 4; v++)
        run_one("R3 R5 three-ch", 40'(v) << 15 | 40'(v) << 7 | 40'h1234_0000_0, gid, 8, 3);
  endtask

  task automatic t_mod6;
    for (int gid = 0; gid < 8; gid++)
      for (int v = 0; v < 4; v++)
        run_one("R4 R5 six-ch", 40'(v) << 17 | 40'(v) << 7 | 40'h0A_0000_0000, gid, 5, 6);
  endtask

  task automatic t_gsize;
    for (int p = 0; p <= 11; p++)
      run_one("R6 gsize", 40'h00_0001_8000, 1, (1 << p) - 1, 3);
  endtask

  task automatic t_bad;
    run_one("R7 zero", 40'h55_5555_5555, 3, 7, 0);
    run_one("R7 five", 40'h01_2345_6789, 2, 7, 5);
    run_one("R7 fifteen", 40'hFE_DCBA_9876, 1, 7, 15);
  endtask

  task automatic t_hold;
    logic [42:0] prev;
    run_one("R10 setup", 40'h33_0000_8000, 2, 1, 3);
    prev = out_sys_addr;
    in_valid = 1'b0; in_port_addr = 40'h11_1111_1111; in_chnls = 4'd5;
    repeat (2) @(negedge clk);
    check("R10 hold addr", 64'(out_sys_addr), 64'(prev));
    check("R10 hold flag", 64'(out_cfg_bad), 64'd0);
    check("R10 valid low", 64'(out_valid), 64'd0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_pass;
        t_insert;
        t_mod3;
        t_mod6;
        t_gsize;
        t_bad;
        t_hold;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule